// File: doc/BRIEF.md
# Wide Cycle Counter with Torn-Read Detection

The block is a free-running cycle counter of twice the register width (64 bits by default). Software reads it through a 32-bit register port. Because a full count takes two reads, the high half can roll over between them, or an interrupt can be taken between them. Either event leaves software with a pair of words that never existed together.

A small tracker watches every low-word read and the high-word read that follows it. It raises a validity flag only when the pair forms one consistent snapshot. Software reads the low word, then the high word, then the control register. It repeats the sequence until the validity flag is set. Interrupts and exceptions reach the block as a one-cycle pulse.

Top module: `split_cycle_counter`

## Requirements
- R1: While enabled, the count (2*HALF_W bits, 64 by default) rises by exactly one each clock and wraps from all ones to zero.
- R2: After reset the count is zero, counting is disabled, the validity flag is 0 and the read data is 0. While disabled, the count holds its value.
- R3: Writing the control register (address 0x103) sets the enable from write-data bit 0, and counting follows from the next cycle. A control read returns the enable in bit 0, the validity flag in bit 31 and zero in every other bit.
- R4: Read data is registered and appears on the cycle after the read strobe. Address 0x104 returns the low half, 0x105 returns the high half (both zero-extended), and any other address returns 0.
- R5: A low-word read followed by a high-word read reports the validity flag as 1, provided no interrupt pulse falls between them and the high half did not change between them.
- R6: An interrupt pulse in any cycle after the low-word read, up to and including the cycle of the high-word read, makes the flag 0. A pulse in the same cycle as the low-word read does not count.
- R7: If the high half at the high-word read differs from its value at the low-word read, the flag is 0.
- R8: A high-word read with no pending low-word read sets the flag to 0. This includes a second high read after a completed pair.
- R9: A low-word read restarts tracking and clears the flag to 0. Control reads and writes leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| exc_pulse | input | 1 | One-cycle pulse when an interrupt or exception is taken |

## Verification
The embedded assertions check the cycle-level rules on every cycle. These are the single-step increment and the carry into the high half, the hold while disabled, and the rules that an interrupt, a changed high half or an orphan high read can never leave the validity flag set. They also check that a low read always clears the flag and that control reads return the live enable. Only the bench scenarios can show the register-level behaviour that software sees: the order of low, high and control reads, the word values matching an independent count model, wrap-around of the full count, and retry after a torn pair. To make carries and wrap reachable, the bench instantiates the block with a narrow half width.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   typedef enum logic [1:0] {
      TRK_IDLE    = 2'd0,
      TRK_ARMED   = 2'd1,
      TRK_TAINTED = 2'd2,
      TRK_VALID   = 2'd3
   } trk_state_e;
endpackage

// File: rtl/ctr_counter.sv
module ctr_counter #(
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   output logic [HALF_W-1:0] cnt_lo,
   output logic [HALF_W-1:0] cnt_hi
);
   logic lo_full;
   assign lo_full = &cnt_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else if (en) begin
         cnt_lo <= cnt_lo + 1'b1;
         if (lo_full) cnt_hi <= cnt_hi + 1'b1;
      end
   end

   // R1: a full low half rolls to zero and carries into the high half
   a_r1_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (en && lo_full) |=> (cnt_lo == '0) && (cnt_hi == $past(cnt_hi) + 1'b1));
endmodule

// File: rtl/ctr_tracker.sv
module ctr_tracker
   import ctr_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_rd,
   input  logic              hi_rd,
   input  logic              exc,
   input  logic [HALF_W-1:0] hi_now,
   output logic              pair_ok
);
   trk_state_e        state, state_nx;
   logic [HALF_W-1:0] hi_snap;

   always_comb begin
      state_nx = state;
      if (lo_rd) begin
         state_nx = TRK_ARMED;
      end else if (hi_rd) begin
         if (state == TRK_ARMED && !exc && hi_now == hi_snap) state_nx = TRK_VALID;
         else                                                 state_nx = TRK_IDLE;
      end else if (state == TRK_ARMED && exc) begin
         state_nx = TRK_TAINTED;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= TRK_IDLE;
         hi_snap <= '0;
      end else begin
         state <= state_nx;
         if (lo_rd) hi_snap <= hi_now;
      end
   end

   assign pair_ok = (state == TRK_VALID);

   // R6: an interrupt in the high-read cycle spoils the pair
   a_r6_exc_at_high: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd && exc) |=> !pair_ok);
   // R6: an interrupt while armed spoils the pair
   a_r6_exc_armed: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_ARMED && exc && !lo_rd && !hi_rd) |=> (state == TRK_TAINTED));
   // R7: the high half moved since the low read
   a_r7_high_moved: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd && hi_now != hi_snap) |=> !pair_ok);
   // R8: a high read with no pending low read
   a_r8_orphan_high: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_rd && state != TRK_ARMED) |=> !pair_ok);
   // R9: a low read always clears the flag
   a_r9_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd |=> !pair_ok);
endmodule

// File: rtl/ctr_regport.sv
module ctr_regport #(
   parameter int          HALF_W    = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 12,
   parameter logic [11:0] CTRL_ADDR = 12'h103,
   parameter logic [11:0] LO_ADDR   = 12'h104,
   parameter logic [11:0] HI_ADDR   = 12'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [HALF_W-1:0] cnt_lo,
   input  logic [HALF_W-1:0] cnt_hi,
   input  logic              pair_ok,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              count_en,
   output logic              lo_rd,
   output logic              hi_rd
);
   localparam int STATUS_BIT = DATA_W - 1;
   localparam int ENABLE_BIT = 0;

   logic              sel_ctrl, sel_lo, sel_hi;
   logic [DATA_W-1:0] lo_ext, hi_ext, ctrl_val, rd_mux;
   logic              unused_wdata_bits;

   assign sel_ctrl = (bus_addr == CTRL_ADDR[ADDR_W-1:0]);
   assign sel_lo   = (bus_addr == LO_ADDR[ADDR_W-1:0]);
   assign sel_hi   = (bus_addr == HI_ADDR[ADDR_W-1:0]);
   assign lo_rd    = bus_rd && sel_lo;
   assign hi_rd    = bus_rd && sel_hi;
   assign unused_wdata_bits = ^bus_wdata[DATA_W-1:1];

   generate
      if (HALF_W == DATA_W) begin : g_full_width
         assign lo_ext = cnt_lo;
         assign hi_ext = cnt_hi;
      end else begin : g_zero_ext
         assign lo_ext = {{(DATA_W-HALF_W){1'b0}}, cnt_lo};
         assign hi_ext = {{(DATA_W-HALF_W){1'b0}}, cnt_hi};
      end
   endgenerate

   always_comb begin
      ctrl_val             = '0;
      ctrl_val[ENABLE_BIT] = count_en;
      ctrl_val[STATUS_BIT] = pair_ok;
   end

   always_comb begin
      if (sel_ctrl)    rd_mux = ctrl_val;
      else if (sel_lo) rd_mux = lo_ext;
      else if (sel_hi) rd_mux = hi_ext;
      else             rd_mux = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_en  <= 1'b0;
         bus_rdata <= '0;
      end else begin
         if (bus_wr && sel_ctrl) count_en <= bus_wdata[ENABLE_BIT];
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end

   // R3: a control read returns the live enable in bit 0
   a_r3_ctrl_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_ctrl) |=> (bus_rdata[ENABLE_BIT] == $past(count_en)));
   // R4: reads of unmapped addresses return zero
   a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !sel_ctrl && !sel_lo && !sel_hi) |=> (bus_rdata == '0));
endmodule

// File: rtl/split_cycle_counter.sv
module split_cycle_counter #(
   parameter int          HALF_W    = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 12,
   parameter logic [11:0] CTRL_ADDR = 12'h103,
   parameter logic [11:0] LO_ADDR   = 12'h104,
   parameter logic [11:0] HI_ADDR   = 12'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              exc_pulse
);
   localparam int COUNT_W = 2 * HALF_W;

   generate
      if (HALF_W < 2 || HALF_W > DATA_W) begin : g_bad_half
         $error("HALF_W must lie between 2 and DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie between 1 and 12");
      end
      if (CTRL_ADDR == LO_ADDR || CTRL_ADDR == HI_ADDR || LO_ADDR == HI_ADDR) begin : g_bad_map
         $error("register addresses must be distinct");
      end
   endgenerate

   logic              count_en, lo_rd, hi_rd, pair_ok;
   logic [HALF_W-1:0] cnt_lo, cnt_hi;
   logic [COUNT_W-1:0] cnt_full;

   assign cnt_full = {cnt_hi, cnt_lo};

   ctr_counter #(.HALF_W(HALF_W)) i_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (count_en),
      .cnt_lo (cnt_lo),
      .cnt_hi (cnt_hi)
   );

   ctr_tracker #(.HALF_W(HALF_W)) i_tracker (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_rd   (lo_rd),
      .hi_rd   (hi_rd),
      .exc     (exc_pulse),
      .hi_now  (cnt_hi),
      .pair_ok (pair_ok)
   );

   ctr_regport #(
      .HALF_W(HALF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
   ) i_regport (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .cnt_lo    (cnt_lo),
      .cnt_hi    (cnt_hi),
      .pair_ok   (pair_ok),
      .bus_rdata (bus_rdata),
      .count_en  (count_en),
      .lo_rd     (lo_rd),
      .hi_rd     (hi_rd)
   );

   // R1: one step per enabled cycle, across the full width
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      count_en |=> (cnt_full == $past(cnt_full) + 1'b1));
   // R2: the count holds while disabled
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> $stable(cnt_full));
endmodule

// File: tb/test_split_cycle_counter.sv
module test_split_cycle_counter;
   localparam int HALF_W = 8;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 12;
   localparam logic [ADDR_W-1:0] A_CTRL = 12'h103;
   localparam logic [ADDR_W-1:0] A_LO   = 12'h104;
   localparam logic [ADDR_W-1:0] A_HI   = 12'h105;
   localparam logic [DATA_W-1:0] M_ALL  = '1;
   localparam logic [DATA_W-1:0] M_STAT = 32'h8000_0000;
   localparam logic [DATA_W-1:0] M_EN   = 32'h0000_0001;

   typedef struct {
      logic [DATA_W-1:0] exp;
      logic [DATA_W-1:0] mask;
      string             tag;
   } item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0, bus_wr = 1'b0, exc_pulse = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;

   int checks = 0, fails = 0;
   item_t sb_q[$];
   logic rd_seen = 1'b0;
   logic [2*HALF_W-1:0] m_cnt = '0;
   logic m_en = 1'b0;

   always #10 clk = ~clk;

   split_cycle_counter #(.HALF_W(HALF_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_split_cycle_counter (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .exc_pulse(exc_pulse)
   );

   // reference count model built from R1, R2, R3
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0;
         m_en  <= 1'b0;
      end else begin
         if (m_en) m_cnt <= m_cnt + 1'b1;
         if (bus_wr && bus_addr == A_CTRL) m_en <= bus_wdata[0];
      end
      rd_seen <= bus_rd;
   end

   task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: results appear the cycle after each read strobe (R4)
   always @(negedge clk) begin
      if (rd_seen && rst_n) begin
         if (sb_q.size() == 0) begin
            check("R4 unexpected read data", 32'h0, 32'h1);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, bus_rdata & it.mask, it.exp & it.mask);
         end
      end
   end

   // driver: call at a negedge; leaves at the next negedge
   task automatic rd_reg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                         input logic [DATA_W-1:0] mask, input string tag);
      item_t it;
      it.exp = exp; it.mask = mask; it.tag = tag;
      sb_q.push_back(it);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd_lo(input string tag);
      rd_reg(A_LO, {{(DATA_W-HALF_W){1'b0}}, m_cnt[HALF_W-1:0]}, M_ALL, tag);
   endtask

   task automatic rd_hi(input string tag);
      rd_reg(A_HI, {{(DATA_W-HALF_W){1'b0}}, m_cnt[2*HALF_W-1:HALF_W]}, M_ALL, tag);
   endtask

   task automatic rd_status(input logic ok, input string tag);
      rd_reg(A_CTRL, {ok, {(DATA_W-1){1'b0}}}, M_STAT, tag);
   endtask

   task automatic wr_ctrl(input logic [DATA_W-1:0] d);
      bus_addr = A_CTRL; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic drain();
      @(negedge clk);
      @(negedge clk);
   endtask

   logic done = 1'b0;

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R2: reset state
      check("R2 reset rdata", bus_rdata, '0);
      rst_n = 1'b1;
      idle(2);
      rd_reg(A_CTRL, 32'h0, M_ALL, "R2 R3 reset control all zero");
      idle(5);
      rd_lo("R2 count held at zero while disabled");
      rd_hi("R2 high zero while disabled");
      rd_reg(12'h0A7, 32'h0, M_ALL, "R4 unmapped address");
      drain();

      // R3: enable
      wr_ctrl(32'hFFFF_FFFF);
      rd_reg(A_CTRL, 32'h1, M_ALL & ~M_STAT, "R3 control readback enable");
      idle(7);
      // R1 R4 R5: clean pair
      rd_lo("R1 low word tracks count");
      rd_hi("R1 high word tracks count");
      rd_status(1'b1, "R5 clean pair valid");
      rd_status(1'b1, "R9 control read keeps flag");
      drain();

      // R6: interrupt between reads
      rd_lo("R6 low word");
      exc_pulse = 1'b1; @(negedge clk); exc_pulse = 1'b0;
      rd_hi("R6 high word");
      rd_status(1'b0, "R6 interrupt between reads");
      drain();
      // R6: interrupt in the high read cycle
      rd_lo("R6 low word b");
      exc_pulse = 1'b1;
      rd_hi("R6 high word b");
      exc_pulse = 1'b0;
      rd_status(1'b0, "R6 interrupt at high read");
      drain();
      // R6: interrupt in the low read cycle is ignored
      exc_pulse = 1'b1;
      rd_lo("R6 low word c");
      exc_pulse = 1'b0;
      rd_hi("R6 high word c");
      rd_status(1'b1, "R6 interrupt at low read ignored");
      // R8: orphan high read after completed pair
      rd_hi("R8 high word");
      rd_status(1'b0, "R8 second high read invalid");
      drain();
      // R9: low read restarts tracking
      rd_lo("R9 first low");
      exc_pulse = 1'b1; @(negedge clk); exc_pulse = 1'b0;
      rd_lo("R9 second low");
      rd_status(1'b0, "R9 low read clears flag");
      rd_hi("R9 high after restart");
      rd_status(1'b1, "R9 retry gives valid pair");
      drain();
      // R7: carry into high half between the reads
      while (m_cnt[HALF_W-1:0] != '1) @(negedge clk);
      rd_lo("R7 low word at all ones");
      rd_hi("R7 high word after carry");
      rd_status(1'b0, "R7 high half moved");
      drain();
      // R1: wrap of the full count
      while (m_cnt != '1) @(negedge clk);
      idle(3);
      rd_lo("R1 low after wrap");
      rd_hi("R1 high after wrap");
      rd_status(1'b1, "R5 pair after wrap");
      check("R1 model wrapped", {31'h0, m_cnt < 16'd16}, 32'h1);
      drain();
      // R2: disable holds the count
      wr_ctrl(32'h0);
      idle(2);
      rd_lo("R2 low held a");
      idle(6);
      rd_lo("R2 low held b");
      rd_reg(A_CTRL, 32'h0, M_EN, "R3 enable cleared");
      drain();
      if (sb_q.size() != 0) check("R4 pending reads", 32'(sb_q.size()), 32'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule